// File: doc/BRIEF.md
# Program Counter Sequencer with Circular Return Stack

This block holds the 13-bit program counter of a small processor core and decides, every clock, where the next fetch comes from. The decoder and the interrupt logic outside the block raise one of a set of control strobes: step to the next word, jump or call to an 11-bit target taken from the opcode, overwrite the low byte of the counter with a data value, return, or enter the interrupt handler. A 5-bit upper-address latch, written through its own strobe, provides the bits the opcode or the data byte cannot supply. A jump uses only the top two latch bits. A low-byte write uses all five.

Return addresses go into an 8-entry stack of 13-bit words. A call stores the address after the call. An interrupt stores the address that was about to execute. The stack is a ring: it never refuses a push and never reports an overflow. Once eight entries are in use, each further push replaces the oldest one. A pop with nothing pushed walks the pointer backwards and hands back whatever that slot holds. Only 1K words of program memory exist, so the fetch address presented to memory is the counter folded into its low 10 bits. The low byte of the counter is readable as a port.

Top module: `pc_return_unit`

## Requirements
- R1: While reset is asserted, and in the cycle after it is released, the fetch address, the readable low byte and the latch all read 0.
- R2: A step strobe sets the counter to counter+1 modulo 2^13, so 0x1FFF steps to 0x0000.
- R3: A jump sets counter[10:0] to the 11-bit target and counter[12:11] to latch bits [4:3].
- R4: A low-byte write sets counter[7:0] to the data byte and counter[12:8] to latch bits [4:0], using the latch value from before any latch write in the same cycle.
- R5: The fetch address equals counter[9:0] with bits [12:10] zero. The readable low byte equals counter[7:0].
- R6: An interrupt strobe sets the counter to 0x0004 and pushes the counter value it had before that edge.
- R7: A call pushes counter+1 and loads the counter the same way a jump does.
- R8: A return loads the counter with the most recently pushed entry that has not yet been popped.
- R9: The stack holds 8 entries as a ring. After nine pushes, the ninth entry has replaced the first, so eight returns yield pushes nine down to two, and a ninth return yields the ninth push again.
- R10: A return with no live entry moves the pointer back one slot and loads that slot's content. All slots are 0 after reset.
- R11: When several strobes are raised together, one is served, in the priority order interrupt, return, call, jump, low-byte write, step.
- R12: The latch changes only on its own write strobe. Pushes and pops never alter it, and its value is readable on a port.
- R13: With no strobe raised, the counter keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_i | input | 1 | Advance to the next word |
| jump_i | input | 1 | Jump to the opcode target |
| call_i | input | 1 | Call the opcode target, pushing the return address |
| tgt_i | input | 11 | Target field of the opcode |
| pcl_wr_i | input | 1 | Write the low byte of the counter |
| pcl_data_i | input | 8 | Data for the low-byte write |
| ret_i | input | 1 | Return: pop the stack into the counter |
| irq_i | input | 1 | Enter the interrupt vector, pushing the counter |
| latch_wr_i | input | 1 | Write the upper-address latch |
| latch_data_i | input | 5 | Data for the latch write |
| fetch_addr_o | output | 13 | Program memory fetch address, folded into 1K words |
| pcl_o | output | 8 | Readable low byte of the counter |
| latch_o | output | 5 | Current upper-address latch value |

## Verification
Jumps and low-byte writes are driven with latch values whose top two bits differ from their lower three. This shows which slice each load takes, and it shows that a latch write in the same cycle arrives too late for a low-byte write. Call and interrupt entries are tested both nested and interleaved. This separates the PC+1 push of a call from the plain-PC push of an interrupt. A run of nine calls followed by more returns than pushes covers the ring overwrite and the pointer wrap on underflow. Strobes raised in groups confirm the service order, and a step at 0x1FFF together with targets above 1K shows the counter rolling over and the fetch address folding.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  typedef enum logic [2:0] {
    OP_HOLD = 3'd0,
    OP_STEP = 3'd1,
    OP_PCLW = 3'd2,
    OP_JUMP = 3'd3,
    OP_CALL = 3'd4,
    OP_RET  = 3'd5,
    OP_IRQ  = 3'd6
  } pc_op_e;
endpackage

// File: rtl/pcs_opsel.sv
module pcs_opsel (
  input  logic             step_i,
  input  logic             jump_i,
  input  logic             call_i,
  input  logic             pcl_wr_i,
  input  logic             ret_i,
  input  logic             irq_i,
  output pcs_pkg::pc_op_e  op_o
);
  import pcs_pkg::*;

  // fixed service order: vectoring first, plain stepping last
  always_comb begin
    if (irq_i)         op_o = OP_IRQ;
    else if (ret_i)    op_o = OP_RET;
    else if (call_i)   op_o = OP_CALL;
    else if (jump_i)   op_o = OP_JUMP;
    else if (pcl_wr_i) op_o = OP_PCLW;
    else if (step_i)   op_o = OP_STEP;
    else               op_o = OP_HOLD;
  end
endmodule

// File: rtl/pcs_ret_stack.sv
module pcs_ret_stack #(
  parameter int W     = 13,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic [W-1:0] push_val_i,
  output logic [W-1:0] top_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

  logic [PTR_W-1:0] ptr_q;
  logic [W-1:0]     slot_q [DEPTH];

  function automatic logic [PTR_W-1:0] ptr_fwd(input logic [PTR_W-1:0] p);
    return (p == PTR_LAST) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [PTR_W-1:0] ptr_back(input logic [PTR_W-1:0] p);
    return (p == '0) ? PTR_LAST : p - 1'b1;
  endfunction

  // pointer marks the next free slot; it wraps instead of saturating
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (push_i) ptr_q <= ptr_fwd(ptr_q);
    else if (pop_i)  ptr_q <= ptr_back(ptr_q);
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic wr_en;
    assign wr_en = push_i && (ptr_q == PTR_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     slot_q[g] <= '0;
      else if (wr_en) slot_q[g] <= push_val_i;
    end
  end

  assign top_o = slot_q[ptr_back(ptr_q)];
endmodule

// File: rtl/pc_return_unit.sv
module pc_return_unit #(
  parameter int PC_W      = 13,
  parameter int TGT_W     = 11,
  parameter int LAT_W     = 5,
  parameter int LO_W      = 8,
  parameter int IMPL_W    = 10,
  parameter int STK_DEPTH = 8,
  parameter int VEC_RST   = 0,
  parameter int VEC_IRQ   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_i,
  input  logic              jump_i,
  input  logic              call_i,
  input  logic [TGT_W-1:0]  tgt_i,
  input  logic              pcl_wr_i,
  input  logic [LO_W-1:0]   pcl_data_i,
  input  logic              ret_i,
  input  logic              irq_i,
  input  logic              latch_wr_i,
  input  logic [LAT_W-1:0]  latch_data_i,
  output logic [PC_W-1:0]   fetch_addr_o,
  output logic [LO_W-1:0]   pcl_o,
  output logic [LAT_W-1:0]  latch_o
);
  import pcs_pkg::*;

  localparam int JHI_W = PC_W - TGT_W;

  function automatic logic [PC_W-1:0] f_inc(input logic [PC_W-1:0] p);
    return p + 1'b1;
  endfunction

  function automatic logic [PC_W-1:0] f_jump(input logic [LAT_W-1:0] l,
                                             input logic [TGT_W-1:0] t);
    return {l[LAT_W-1 -: JHI_W], t};
  endfunction

  function automatic logic [PC_W-1:0] f_pclw(input logic [LAT_W-1:0] l,
                                             input logic [LO_W-1:0]  d);
    return PC_W'({l, d});
  endfunction

  function automatic logic [PC_W-1:0] f_fold(input logic [PC_W-1:0] p);
    return PC_W'(p[IMPL_W-1:0]);
  endfunction

  pc_op_e          op_sel;
  logic [PC_W-1:0] pc_q, pc_d;
  logic [LAT_W-1:0] latch_q;
  logic            push_ev, pop_ev;
  logic [PC_W-1:0] push_val, stk_top;

  pcs_opsel u_opsel (
    .step_i   (step_i),
    .jump_i   (jump_i),
    .call_i   (call_i),
    .pcl_wr_i (pcl_wr_i),
    .ret_i    (ret_i),
    .irq_i    (irq_i),
    .op_o     (op_sel)
  );

  assign push_ev  = (op_sel == OP_CALL) || (op_sel == OP_IRQ);
  assign pop_ev   = (op_sel == OP_RET);
  assign push_val = (op_sel == OP_CALL) ? f_inc(pc_q) : pc_q;

  pcs_ret_stack #(.W(PC_W), .DEPTH(STK_DEPTH)) u_stack (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_i     (push_ev),
    .pop_i      (pop_ev),
    .push_val_i (push_val),
    .top_o      (stk_top)
  );

  always_comb begin
    unique case (op_sel)
      OP_IRQ:  pc_d = PC_W'(VEC_IRQ);
      OP_RET:  pc_d = stk_top;
      OP_CALL: pc_d = f_jump(latch_q, tgt_i);
      OP_JUMP: pc_d = f_jump(latch_q, tgt_i);
      OP_PCLW: pc_d = f_pclw(latch_q, pcl_data_i);
      OP_STEP: pc_d = f_inc(pc_q);
      default: pc_d = pc_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= PC_W'(VEC_RST);
    else        pc_q <= pc_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          latch_q <= '0;
    else if (latch_wr_i) latch_q <= latch_data_i;
  end

  assign fetch_addr_o = f_fold(pc_q);
  assign pcl_o        = pc_q[LO_W-1:0];
  assign latch_o      = latch_q;
endmodule

// File: rtl/pcs_chk.sv
module pcs_chk #(
  parameter int PC_W    = 13,
  parameter int TGT_W   = 11,
  parameter int LAT_W   = 5,
  parameter int LO_W    = 8,
  parameter int IMPL_W  = 10,
  parameter int VEC_IRQ = 4
) (
  input logic             clk,
  input logic             rst_n,
  input pcs_pkg::pc_op_e  op,
  input logic [PC_W-1:0]  pc,
  input logic [LAT_W-1:0] latch,
  input logic [TGT_W-1:0] tgt,
  input logic [LO_W-1:0]  pcl_data,
  input logic [PC_W-1:0]  fetch,
  input logic             latch_wr,
  input logic             push_ev,
  input logic             pop_ev,
  input logic             irq
);
  import pcs_pkg::*;
  localparam int JHI_W = PC_W - TGT_W;

  logic [JHI_W-1:0] jhi;
  assign jhi = latch[LAT_W-1 -: JHI_W];

  // R2
  a_r2_step_adds_one: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_STEP |=> pc == PC_W'($past(pc) + 1'b1));

  // R3
  a_r3_jump_slices: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_JUMP |=> pc == {$past(jhi), $past(tgt)});

  // R4
  a_r4_low_byte_write: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_PCLW |=> pc == PC_W'({$past(latch), $past(pcl_data)}));

  // R5
  a_r5_fetch_folds: assert property (@(posedge clk) disable iff (!rst_n)
    fetch[PC_W-1:IMPL_W] == '0 && fetch[IMPL_W-1:0] == pc[IMPL_W-1:0]);

  // R6
  a_r6_irq_vector: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> pc == PC_W'(VEC_IRQ));

  // R11
  a_r11_irq_first: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> op == OP_IRQ && push_ev && !pop_ev);

  // R12
  a_r12_latch_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ev || pop_ev) && !latch_wr |=> $stable(latch));

  // R13
  a_r13_hold: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_HOLD |=> $stable(pc));
endmodule

bind pc_return_unit pcs_chk #(
  .PC_W(PC_W), .TGT_W(TGT_W), .LAT_W(LAT_W), .LO_W(LO_W),
  .IMPL_W(IMPL_W), .VEC_IRQ(VEC_IRQ)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .op       (op_sel),
  .pc       (pc_q),
  .latch    (latch_q),
  .tgt      (tgt_i),
  .pcl_data (pcl_data_i),
  .fetch    (fetch_addr_o),
  .latch_wr (latch_wr_i),
  .push_ev  (push_ev),
  .pop_ev   (pop_ev),
  .irq      (irq_i)
);

// File: tb/pc_return_unit_bench.sv
module pc_return_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        step_i = 0, jump_i = 0, call_i = 0, pcl_wr_i = 0;
  logic        ret_i = 0, irq_i = 0, latch_wr_i = 0;
  logic [10:0] tgt_i = '0;
  logic [7:0]  pcl_data_i = '0;
  logic [4:0]  latch_data_i = '0;
  logic [12:0] fetch_addr_o;
  logic [7:0]  pcl_o;
  logic [4:0]  latch_o;

  int n_chk = 0, n_fail = 0;
  int m_pc = 0, m_lat = 0;
  int ring[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  pc_return_unit u_pc_return_unit (
    .clk(clk), .rst_n(rst_n), .step_i(step_i), .jump_i(jump_i), .call_i(call_i),
    .tgt_i(tgt_i), .pcl_wr_i(pcl_wr_i), .pcl_data_i(pcl_data_i), .ret_i(ret_i),
    .irq_i(irq_i), .latch_wr_i(latch_wr_i), .latch_data_i(latch_data_i),
    .fetch_addr_o(fetch_addr_o), .pcl_o(pcl_o), .latch_o(latch_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // ring kept as a rotating queue: front is the slot that the next push replaces
  function automatic void m_push(input int v);
    void'(ring.pop_front());
    ring.push_back(v);
  endfunction

  function automatic int m_pop();
    int v;
    v = ring.pop_back();
    ring.push_front(v);
    return v;
  endfunction

  task automatic tick(input string tag);
    if (irq_i) begin m_push(m_pc); m_pc = 4; end
    else if (ret_i) m_pc = m_pop();
    else if (call_i) begin
      m_push((m_pc + 1) % 8192);
      m_pc = (m_lat / 8) * 2048 + int'(tgt_i);
    end
    else if (jump_i) m_pc = (m_lat / 8) * 2048 + int'(tgt_i);
    else if (pcl_wr_i) m_pc = m_lat * 256 + int'(pcl_data_i);
    else if (step_i) m_pc = (m_pc + 1) % 8192;
    if (latch_wr_i) m_lat = int'(latch_data_i);
    @(posedge clk);
    #1;
    chk({tag, " fetch"}, int'(fetch_addr_o), m_pc % 1024);
    chk({tag, " low byte"}, int'(pcl_o), m_pc % 256);
    chk({tag, " latch"}, int'(latch_o), m_lat);
    step_i = 0; jump_i = 0; call_i = 0; pcl_wr_i = 0;
    ret_i = 0; irq_i = 0; latch_wr_i = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) ring.push_back(0);
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset fetch", int'(fetch_addr_o), 0);
    chk("R1 reset low byte", int'(pcl_o), 0);
    chk("R1 reset latch", int'(latch_o), 0);
    rst_n = 1;
    tick("R1 first cycle");

    for (int i = 0; i < 3; i++) begin step_i = 1; tick("R2 step"); end
    tick("R13 hold"); tick("R13 hold");

    latch_wr_i = 1; latch_data_i = 5'h16; tick("R12 latch write");
    jump_i = 1; tgt_i = 11'h523; tick("R3 jump");
    pcl_wr_i = 1; pcl_data_i = 8'hA5; latch_wr_i = 1; latch_data_i = 5'h09;
    tick("R4 low byte with old latch");
    latch_wr_i = 1; latch_data_i = 5'h16; tick("R12 latch restore");

    call_i = 1; tgt_i = 11'h010; tick("R7 call");
    step_i = 1; tick("R2 step in callee");
    call_i = 1; tgt_i = 11'h7F0; tick("R7 nested call");
    ret_i = 1; tick("R8 return inner");
    ret_i = 1; tick("R8 return outer");

    step_i = 1; tick("R2 step");
    irq_i = 1; tick("R6 interrupt");
    call_i = 1; tgt_i = 11'h300; tick("R7 call in handler");
    ret_i = 1; tick("R8 return to handler");
    ret_i = 1; tick("R6 return from interrupt");

    irq_i = 1; ret_i = 1; call_i = 1; jump_i = 1; pcl_wr_i = 1; step_i = 1;
    tick("R11 all strobes");
    ret_i = 1; call_i = 1; jump_i = 1; pcl_wr_i = 1; step_i = 1; tgt_i = 11'h111;
    tick("R11 return beats call");
    call_i = 1; jump_i = 1; pcl_wr_i = 1; step_i = 1; tgt_i = 11'h222;
    tick("R11 call beats jump");
    jump_i = 1; pcl_wr_i = 1; step_i = 1; tgt_i = 11'h333; tick("R11 jump beats write");
    pcl_wr_i = 1; step_i = 1; pcl_data_i = 8'h3C; tick("R11 write beats step");

    latch_wr_i = 1; latch_data_i = 5'h1F; tick("R12 latch all ones");
    pcl_wr_i = 1; pcl_data_i = 8'hFF; tick("R4 top of space");
    step_i = 1; tick("R2 rollover");

    for (int i = 0; i < 9; i++) begin
      call_i = 1; tgt_i = 11'(16 * i + 7);
      if (i == 4) begin latch_wr_i = 1; latch_data_i = 5'h0B; end
      tick("R9 push run");
    end
    for (int i = 0; i < 9; i++) begin ret_i = 1; tick("R9 pop run"); end
    for (int i = 0; i < 4; i++) begin ret_i = 1; tick("R10 underflow pop"); end
    step_i = 1; tick("R12 latch after pops");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule